// File: doc/BRIEF.md
# Ternary Tag Merge Controller

This block compacts the tag table of a fully associative cache whose tags end in a few ternary positions. When a line has just been admitted, the controller compares it with every resident entry. An entry qualifies as a partner when it belongs to the same task, carries the same privacy flag, has the same number of wildcard positions, and differs only in the lowest position that is still definite. When a partner qualifies, the two entries merge into one. The entry whose differing bit is 0 survives and has that bit turned into a wildcard. The data slots of the other entry are packed into the survivor's free slots, and the other entry is released. The widened survivor is then compared with the table again, so merges can chain until nothing qualifies or no definite ternary position is left.

Each tag entry owns 2^TERN_W data slots. Slot `s` of entry `e` is addressed as the pair (e, s). The controller never touches data itself. It issues one copy command per cycle, and the data array performs the copy. The tag table is reached through a combinational read port and a one-entry write port. The work is off the lookup path, and the lookup compare and the eviction choice are outside the block. The allocator places the new line's data in slot 0 of the reserved entry `new_idx`, leaves that entry invalid, and pulses `start`.

Top module: `agg_tag_merge`

## Requirements
- R1: After reset, `busy`, `done`, `wr_en` and `cp_en` are 0. No write or copy is issued while the block is idle.
- R2: Two entries form a pair only if all of the following hold: the partner is valid; the task IDs match; the privacy flags match; the wildcard masks are equal; at least one ternary position is still definite; and the tags, with wildcard positions ignored, differ in exactly the lowest definite position. A difference anywhere else in the tag blocks the merge.
- R3: The survivor is the entry that has 0 in the differing position. The survivor is written back at its own index with valid 1. Its wildcard mask gains that position, the mask always stays a run of ones starting at bit 0, and the tag bit at that position is stored as 0.
- R4: Every valid slot of the absorbed entry is copied in ascending source-slot order into the lowest free slot of the survivor. Exactly one copy is issued per cycle, and the survivor's slot-valid mask becomes the union.
- R5: An absorbed entry that was resident is written back with valid 0 and an empty slot mask. When the new line itself is absorbed, its reserved index is never written and stays invalid.
- R6: After each merge, the widened survivor is compared with the table again, scanning from index 0 and taking the lowest-indexed qualifying partner. Merging repeats until no partner qualifies or all ternary positions are wildcards.
- R7: If the new line finds no partner, it is written at `new_idx` with a wildcard mask of 0, slot mask 1 (slot 0 only), and its own tag, task ID and flag.
- R8: `busy` is 1 from the cycle after `start` until `done`. `done` is a one-cycle pulse, after which the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | New line admitted; begin merging |
| new_idx | input | IDX_W | Reserved entry index holding the new line |
| new_tag | input | TAG_W | Tag of the new line |
| new_pid | input | PID_W | Task ID of the new line |
| new_priv | input | 1 | Private flag of the new line |
| busy | output | 1 | Merge chain in progress |
| done | output | 1 | One-cycle end-of-chain pulse |
| rd_idx | output | IDX_W | Tag table read index |
| rd_valid | input | 1 | Read entry valid |
| rd_priv | input | 1 | Read entry private flag |
| rd_pid | input | PID_W | Read entry task ID |
| rd_tag | input | TAG_W | Read entry tag |
| rd_dc | input | TERN_W | Read entry wildcard mask |
| rd_mask | input | SLOTS | Read entry slot-valid mask |
| wr_en | output | 1 | Tag table write strobe |
| wr_idx | output | IDX_W | Write index |
| wr_valid | output | 1 | Written valid bit |
| wr_priv | output | 1 | Written private flag |
| wr_pid | output | PID_W | Written task ID |
| wr_tag | output | TAG_W | Written tag |
| wr_dc | output | TERN_W | Written wildcard mask |
| wr_mask | output | SLOTS | Written slot-valid mask |
| cp_en | output | 1 | Slot copy command |
| cp_src_idx | output | IDX_W | Source entry |
| cp_src_slot | output | TERN_W | Source slot |
| cp_dst_idx | output | IDX_W | Destination entry |
| cp_dst_slot | output | TERN_W | Destination slot |

## Verification
The bench targets the following corner cases:

- Near misses that must not merge: a task or privacy mismatch, unequal wildcard counts, a difference one bit too high, and a difference in the upper tag. A design that loosened any one of the pair rules would merge and leave a wrong table.
- Both survivor polarities: the new line surviving and the new line being absorbed. Picking the wrong survivor, or writing the reserved index when the new line is absorbed, leaves a valid entry where none belongs.
- A three-step chain and a chain that runs until every ternary position is a wildcard. A controller that stops after one merge, or packs slots out of order, ends up with the wrong wildcard mask, wrong slot data, or a wrong copy count.
- Random tables with a narrow tag range, to exercise many chained merges.

// File: rtl/agg_pkg.sv
package agg_pkg;
    typedef enum logic [2:0] {
        AG_IDLE,
        AG_SCAN,
        AG_COPY,
        AG_WLOW,
        AG_WHIGH,
        AG_FIN,
        AG_DONE
    } agg_state_e;
endpackage

// File: rtl/agg_pair_match.sv
module agg_pair_match #(
    parameter int TAG_W  = 10,
    parameter int TERN_W = 3,
    parameter int PID_W  = 3
) (
    input  logic [TAG_W-1:0]  a_tag,
    input  logic [TERN_W-1:0] a_dc,
    input  logic [PID_W-1:0]  a_pid,
    input  logic              a_priv,
    input  logic              b_valid,
    input  logic [TAG_W-1:0]  b_tag,
    input  logic [TERN_W-1:0] b_dc,
    input  logic [PID_W-1:0]  b_pid,
    input  logic              b_priv,
    output logic              hit,
    output logic              a_low,
    output logic [TERN_W-1:0] wide_dc,
    output logic [TAG_W-1:0]  step_bit
);
    logic [TERN_W:0]  step_w;
    logic [TAG_W-1:0] dc_ext;
    logic [TAG_W-1:0] diff;

    always_comb begin
        // wildcards form a run from bit 0, so +1 lands on the lowest definite bit
        step_w              = {1'b0, a_dc} + 1'b1;
        step_bit            = '0;
        step_bit[TERN_W:0]  = step_w;
        dc_ext              = '0;
        dc_ext[TERN_W-1:0]  = a_dc;
        diff                = (a_tag ^ b_tag) & ~dc_ext;
        hit      = b_valid && (a_pid == b_pid) && (a_priv == b_priv) &&
                   (a_dc == b_dc) && !(&a_dc) && (diff == step_bit);
        a_low    = (a_tag & step_bit) == '0;
        wide_dc  = a_dc | step_w[TERN_W-1:0];
    end
endmodule

// File: rtl/agg_low_one.sv
module agg_low_one #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] pos
);
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                pos   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/agg_tag_merge.sv
module agg_tag_merge
    import agg_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int TAG_W     = 10,
    parameter int TERN_W    = 3,
    parameter int PID_W     = 3,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int SLOTS    = 1 << TERN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  new_idx,
    input  logic [TAG_W-1:0]  new_tag,
    input  logic [PID_W-1:0]  new_pid,
    input  logic              new_priv,
    output logic              busy,
    output logic              done,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_valid,
    input  logic              rd_priv,
    input  logic [PID_W-1:0]  rd_pid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [TERN_W-1:0] rd_dc,
    input  logic [SLOTS-1:0]  rd_mask,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_valid,
    output logic              wr_priv,
    output logic [PID_W-1:0]  wr_pid,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [TERN_W-1:0] wr_dc,
    output logic [SLOTS-1:0]  wr_mask,
    output logic              cp_en,
    output logic [IDX_W-1:0]  cp_src_idx,
    output logic [TERN_W-1:0] cp_src_slot,
    output logic [IDX_W-1:0]  cp_dst_idx,
    output logic [TERN_W-1:0] cp_dst_slot
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [TERN_W-1:0] dc;
        logic [PID_W-1:0]  pid;
        logic              priv;
        logic [SLOTS-1:0]  mask;
        logic [IDX_W-1:0]  idx;
        logic              is_new;
    } cur_t;

    typedef struct packed {
        agg_state_e       state;
        cur_t             cur;
        logic [IDX_W-1:0] j;
        logic [IDX_W-1:0] hidx;
        logic [SLOTS-1:0] hmask;
        logic             hres;
    } regs_t;

    regs_t q, d;

    logic              hit, a_low;
    logic [TERN_W-1:0] wide_dc;
    logic [TAG_W-1:0]  step_bit;
    logic              hs_found, lz_found;
    logic [TERN_W-1:0] hs_pos, lz_pos;

    agg_pair_match #(.TAG_W(TAG_W), .TERN_W(TERN_W), .PID_W(PID_W)) i_match (
        .a_tag(q.cur.tag), .a_dc(q.cur.dc), .a_pid(q.cur.pid), .a_priv(q.cur.priv),
        .b_valid(rd_valid), .b_tag(rd_tag), .b_dc(rd_dc), .b_pid(rd_pid),
        .b_priv(rd_priv), .hit(hit), .a_low(a_low), .wide_dc(wide_dc),
        .step_bit(step_bit)
    );

    agg_low_one #(.W(SLOTS), .IW(TERN_W)) i_src_pick (
        .vec(q.hmask), .found(hs_found), .pos(hs_pos)
    );

    agg_low_one #(.W(SLOTS), .IW(TERN_W)) i_dst_pick (
        .vec(~q.cur.mask), .found(lz_found), .pos(lz_pos)
    );

    always_comb begin
        d           = q;
        rd_idx      = q.j;
        wr_en       = 1'b0;
        wr_idx      = q.cur.idx;
        wr_valid    = 1'b0;
        wr_priv     = q.cur.priv;
        wr_pid      = q.cur.pid;
        wr_tag      = q.cur.tag;
        wr_dc       = q.cur.dc;
        wr_mask     = q.cur.mask;
        cp_en       = 1'b0;
        cp_src_idx  = q.hidx;
        cp_src_slot = hs_pos;
        cp_dst_idx  = q.cur.idx;
        cp_dst_slot = lz_pos;
        busy        = (q.state != AG_IDLE) && (q.state != AG_DONE);
        done        = (q.state == AG_DONE);

        unique case (q.state)
            AG_IDLE: begin
                if (start) begin
                    d.cur.tag    = new_tag;
                    d.cur.dc     = '0;
                    d.cur.pid    = new_pid;
                    d.cur.priv   = new_priv;
                    d.cur.mask   = SLOTS'(1);
                    d.cur.idx    = new_idx;
                    d.cur.is_new = 1'b1;
                    d.j          = '0;
                    d.state      = AG_SCAN;
                end
            end
            AG_SCAN: begin
                if ((q.j != q.cur.idx) && hit) begin
                    if (a_low) begin
                        d.cur.tag = q.cur.tag & ~step_bit;
                        d.hidx    = q.j;
                        d.hmask   = rd_mask;
                        d.hres    = 1'b1;
                    end else begin
                        d.cur.tag    = rd_tag & ~step_bit;
                        d.cur.pid    = rd_pid;
                        d.cur.priv   = rd_priv;
                        d.cur.mask   = rd_mask;
                        d.cur.idx    = q.j;
                        d.cur.is_new = 1'b0;
                        d.hidx       = q.cur.idx;
                        d.hmask      = q.cur.mask;
                        d.hres       = !q.cur.is_new;
                    end
                    d.cur.dc = wide_dc;
                    d.state  = AG_COPY;
                end else if (q.j == IDX_W'(N_ENTRIES - 1)) begin
                    d.state = AG_FIN;
                end else begin
                    d.j = q.j + 1'b1;
                end
            end
            AG_COPY: begin
                if (hs_found) begin
                    cp_en                = 1'b1;
                    d.hmask[hs_pos]      = 1'b0;
                    d.cur.mask[lz_pos]   = 1'b1;
                end else begin
                    d.state = AG_WLOW;
                end
            end
            AG_WLOW: begin
                wr_en        = 1'b1;
                wr_valid     = 1'b1;
                d.cur.is_new = 1'b0;
                d.j          = '0;
                if (q.hres)          d.state = AG_WHIGH;
                else if (&q.cur.dc)  d.state = AG_DONE;
                else                 d.state = AG_SCAN;
            end
            AG_WHIGH: begin
                wr_en    = 1'b1;
                wr_idx   = q.hidx;
                wr_mask  = '0;
                wr_tag   = '0;
                wr_dc    = '0;
                d.state  = (&q.cur.dc) ? AG_DONE : AG_SCAN;
            end
            AG_FIN: begin
                wr_en    = q.cur.is_new;
                wr_valid = 1'b1;
                d.state  = AG_DONE;
            end
            AG_DONE: d.state = AG_IDLE;
            default: d.state = AG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= AG_IDLE;
        end else begin
            q <= d;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_en && !cp_en));
    assert_wide_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid) |-> ((wr_dc & (wr_dc + TERN_W'(1))) == '0));
    assert_room_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cp_en |-> (lz_found && (cp_src_idx != cp_dst_idx)));
    assert_freed_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |-> (wr_mask == '0));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
endmodule

// File: tb/test_agg_tag_merge.sv
module test_agg_tag_merge;
    localparam int N  = 8;
    localparam int TW = 10;
    localparam int LW = 3;
    localparam int PW = 3;
    localparam int IW = 3;
    localparam int S  = 1 << LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [IW-1:0] new_idx = '0;
    logic [TW-1:0] new_tag = '0;
    logic [PW-1:0] new_pid = '0;
    logic new_priv = 1'b0;
    logic busy, done, wr_en, wr_valid, wr_priv, cp_en;
    logic [IW-1:0] rd_idx, wr_idx, cp_src_idx, cp_dst_idx;
    logic [LW-1:0] cp_src_slot, cp_dst_slot, wr_dc;
    logic [PW-1:0] wr_pid;
    logic [TW-1:0] wr_tag;
    logic [S-1:0]  wr_mask;

    logic          t_valid [N];
    logic          t_priv  [N];
    logic [PW-1:0] t_pid   [N];
    logic [TW-1:0] t_tag   [N];
    logic [LW-1:0] t_dc    [N];
    logic [S-1:0]  t_mask  [N];
    logic [7:0]    t_data  [N*S];

    logic          e_valid [N];
    logic          e_priv  [N];
    logic [PW-1:0] e_pid   [N];
    logic [TW-1:0] e_tag   [N];
    logic [LW-1:0] e_dc    [N];
    logic [S-1:0]  e_mask  [N];
    logic [7:0]    e_data  [N*S];

    int checks = 0, fails = 0, ncopy = 0, emoves = 0, cycles = 0;

    always #4 clk = ~clk;

    agg_tag_merge i_agg_tag_merge (
        .clk(clk), .rst_n(rst_n), .start(start), .new_idx(new_idx),
        .new_tag(new_tag), .new_pid(new_pid), .new_priv(new_priv),
        .busy(busy), .done(done), .rd_idx(rd_idx),
        .rd_valid(t_valid[rd_idx]), .rd_priv(t_priv[rd_idx]), .rd_pid(t_pid[rd_idx]),
        .rd_tag(t_tag[rd_idx]), .rd_dc(t_dc[rd_idx]), .rd_mask(t_mask[rd_idx]),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_priv(wr_priv),
        .wr_pid(wr_pid), .wr_tag(wr_tag), .wr_dc(wr_dc), .wr_mask(wr_mask),
        .cp_en(cp_en), .cp_src_idx(cp_src_idx), .cp_src_slot(cp_src_slot),
        .cp_dst_idx(cp_dst_idx), .cp_dst_slot(cp_dst_slot)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (wr_en) begin
            t_valid[wr_idx] <= wr_valid; t_priv[wr_idx] <= wr_priv;
            t_pid[wr_idx] <= wr_pid;     t_tag[wr_idx] <= wr_tag;
            t_dc[wr_idx] <= wr_dc;       t_mask[wr_idx] <= wr_mask;
        end
        if (cp_en) begin
            t_data[int'(cp_dst_idx)*S + int'(cp_dst_slot)] <=
                t_data[int'(cp_src_idx)*S + int'(cp_src_slot)];
            ncopy <= ncopy + 1;
        end
        if (cycles == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_table();
        for (int i = 0; i < N; i++) begin
            t_valid[i] = 0; t_priv[i] = 0; t_pid[i] = 0;
            t_tag[i] = 0; t_dc[i] = 0; t_mask[i] = 0;
        end
        for (int i = 0; i < N*S; i++) t_data[i] = 8'($urandom);
    endtask

    task automatic put(input int i, input logic [TW-1:0] tag, input logic [LW-1:0] dc,
                       input logic [PW-1:0] pid, input logic priv, input logic [S-1:0] m);
        t_valid[i] = 1; t_tag[i] = tag & ~TW'(dc); t_dc[i] = dc;
        t_pid[i] = pid; t_priv[i] = priv; t_mask[i] = m;
    endtask

    // independent reference built from the requirement list
    task automatic model(input int ni, input logic [TW-1:0] tag,
                         input logic [PW-1:0] pid, input logic priv);
        logic [TW-1:0] ctag = tag; logic [LW-1:0] cdc = 0; logic [S-1:0] cmask = 1;
        logic [PW-1:0] cpid = pid; logic cpriv = priv; int cidx = ni; bit cnew = 1;
        bit found;
        for (int i = 0; i < N; i++) begin
            e_valid[i] = t_valid[i]; e_priv[i] = t_priv[i]; e_pid[i] = t_pid[i];
            e_tag[i] = t_tag[i]; e_dc[i] = t_dc[i]; e_mask[i] = t_mask[i];
        end
        for (int i = 0; i < N*S; i++) e_data[i] = t_data[i];
        emoves = 0;
        do begin
            int k = 0, jj = 0, lidx, hidx; bit hres;
            logic [S-1:0] lm, hm; logic [TW-1:0] lt;
            found = 0;
            for (int b = 0; b < LW; b++) if (cdc[b]) k++;
            if (k < LW) begin
                for (int j = 0; j < N; j++)
                    if (!found && j != cidx && e_valid[j] && e_pid[j] == cpid &&
                        e_priv[j] == cpriv && e_dc[j] == cdc &&
                        (((ctag ^ e_tag[j]) & ~TW'(cdc)) == (TW'(1) << k))) begin
                        found = 1; jj = j;
                    end
            end
            if (found) begin
                if (!ctag[k]) begin
                    lidx = cidx; lm = cmask; lt = ctag; hidx = jj; hm = e_mask[jj]; hres = 1;
                end else begin
                    lidx = jj; lm = e_mask[jj]; lt = e_tag[jj];
                    hidx = cidx; hm = cmask; hres = !cnew;
                end
                for (int s = 0; s < S; s++) if (hm[s]) begin
                    int f = 0;
                    while (f < S-1 && lm[f]) f++;
                    e_data[lidx*S + f] = e_data[hidx*S + s];
                    lm[f] = 1; emoves++;
                end
                cdc = cdc | LW'(1 << k); lt[k] = 0;
                e_valid[lidx] = 1; e_tag[lidx] = lt; e_dc[lidx] = cdc; e_mask[lidx] = lm;
                e_pid[lidx] = cpid; e_priv[lidx] = cpriv;
                if (hres) begin e_valid[hidx] = 0; e_mask[hidx] = 0; end
                ctag = lt; cmask = lm; cidx = lidx; cnew = 0;
            end else if (cnew) begin
                e_valid[cidx] = 1; e_tag[cidx] = ctag; e_dc[cidx] = 0; e_mask[cidx] = 1;
                e_pid[cidx] = cpid; e_priv[cidx] = cpriv;
            end
        end while (found);
    endtask

    task automatic run(input int ni, input logic [TW-1:0] tag,
                       input logic [PW-1:0] pid, input logic priv, input string req);
        int w = 0; bit busy_ok = 1;
        model(ni, tag, pid, priv);
        ncopy = 0;
        @(negedge clk);
        start = 1; new_idx = IW'(ni); new_tag = tag; new_pid = pid; new_priv = priv;
        @(negedge clk);
        start = 0;
        while (!done && w < 400) begin
            if (!busy) busy_ok = 0;
            @(negedge clk); w++;
        end
        check(done, {req, "/R8 done"}, done, 1);
        check(busy_ok, {req, "/R8 busy held"}, busy_ok, 1);
        @(negedge clk);
        check(!busy && !done, {req, "/R8 idle after done"}, {busy, done}, 0);
        check(ncopy == emoves, {req, "/R4 copy count"}, ncopy, emoves);
        for (int i = 0; i < N; i++) begin
            check(t_valid[i] == e_valid[i], {req, "/R5 valid"}, t_valid[i], e_valid[i]);
            if (e_valid[i]) begin
                check(t_tag[i] == e_tag[i] && t_dc[i] == e_dc[i], {req, "/R3 tag+dc"},
                      {t_tag[i], t_dc[i]}, {e_tag[i], e_dc[i]});
                check(t_mask[i] == e_mask[i] && t_pid[i] == e_pid[i] &&
                      t_priv[i] == e_priv[i], {req, "/R4 mask"}, t_mask[i], e_mask[i]);
                for (int s = 0; s < S; s++) if (e_mask[i][s])
                    check(t_data[i*S+s] == e_data[i*S+s], {req, "/R4 data"},
                          t_data[i*S+s], e_data[i*S+s]);
            end else begin
                check(t_mask[i] == e_mask[i], {req, "/R5 freed mask"}, t_mask[i], e_mask[i]);
            end
        end
    endtask

    initial begin
        int seed = $urandom(32'h5EED_0A61);
        clear_table();
        repeat (3) @(negedge clk);
        check(!busy && !done && !wr_en && !cp_en, "R1 reset", {busy, done, wr_en, cp_en}, 0);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !done, "R1 idle", {busy, done}, 0);

        // R7: lone line written as-is
        clear_table();
        run(4, 10'h055, 3'd1, 1'b0, "R7 lone");
        check(t_valid[4] && t_dc[4] == 0 && t_mask[4] == 8'h01, "R7 lone entry",
              t_mask[4], 1);

        // R3: new line survives (bit0 = 0)
        clear_table(); put(2, 10'h041, 0, 1, 0, 8'h01);
        run(5, 10'h040, 3'd1, 1'b0, "R3 new low");
        check(t_dc[5] == 3'b001 && t_mask[5] == 8'h03 && !t_valid[2], "R3 new low result",
              t_mask[5], 8'h03);

        // R5: new line absorbed, reserved index untouched
        clear_table(); put(2, 10'h040, 0, 1, 0, 8'h01);
        run(5, 10'h041, 3'd1, 1'b0, "R5 new high");
        check(!t_valid[5] && t_dc[2] == 3'b001, "R5 reserved stays free", t_valid[5], 0);

        // R2 near misses
        clear_table(); put(2, 10'h041, 0, 2, 0, 8'h01);
        run(5, 10'h040, 3'd1, 1'b0, "R2 pid");
        clear_table(); put(2, 10'h041, 0, 1, 1, 8'h01);
        run(5, 10'h040, 3'd1, 1'b0, "R2 priv");
        clear_table(); put(2, 10'h040, 3'b001, 1, 0, 8'h01);
        run(5, 10'h041, 3'd1, 1'b0, "R2 dc count");
        clear_table(); put(2, 10'h042, 0, 1, 0, 8'h01);
        run(5, 10'h040, 3'd1, 1'b0, "R2 high bit");
        clear_table(); put(2, 10'h241, 0, 1, 0, 8'h01);
        run(5, 10'h040, 3'd1, 1'b0, "R2 upper tag");
        check(t_valid[5] && t_valid[2], "R2 no merge", {t_valid[5], t_valid[2]}, 3);

        // R6: chain of two merges
        clear_table(); put(1, 10'h040, 3'b001, 1, 0, 8'h03); put(3, 10'h042, 0, 1, 0, 8'h01);
        run(6, 10'h043, 3'd1, 1'b0, "R6 chain");
        check(t_dc[1] == 3'b011 && t_mask[1] == 8'h0F && !t_valid[3] && ncopy == 3,
              "R6 chain result", t_dc[1], 3'b011);

        // R6: chain until every ternary position is a wildcard
        clear_table(); put(0, 10'h100, 3'b011, 1, 0, 8'h0F); put(2, 10'h104, 3'b001, 1, 0, 8'h05);
        put(4, 10'h106, 0, 1, 0, 8'h01); put(5, 10'h108, 0, 1, 0, 8'h01);
        run(7, 10'h107, 3'd1, 1'b0, "R6 full");
        check(t_dc[0] == 3'b111 && t_mask[0] == 8'hFF && ncopy == 7, "R6 full result",
              t_mask[0], 8'hFF);

        // random tables
        for (int r = 0; r < 60; r++) begin
            int ni = int'($urandom % N);
            clear_table();
            for (int i = 0; i < N; i++) if (i != ni && ($urandom % 4) != 0) begin
                logic [LW-1:0] dc = LW'((1 << ($urandom % 3)) - 1);
                int cnt = 1 + int'($urandom % (1 << $countones(dc)));
                logic [S-1:0] m = 0;
                while ($countones(m) < cnt) m[$urandom % S] = 1;
                put(i, TW'(10'h1A0 | ($urandom % 16)), dc, PW'($urandom % 2), 1'($urandom % 2), m);
            end
            run(ni, TW'(10'h1A0 | ($urandom % 16)), PW'($urandom % 2), 1'($urandom % 2),
                "R2/R6 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule